// File: doc/BRIEF.md
# Horizontal Sync Timing Generator

This block produces the horizontal timing of a monochrome raster display. One pixel period lasts a fixed number of system clocks (four by default). After reset the block waits for one configuration word, which carries the sync pulse length and the combined visible-plus-front-porch length, both in pixel periods. From the cycle after that word is taken, it repeats display lines with no gaps. Each line has three parts: an active-low sync pulse, a back porch of fixed length (120 pixel periods by default, set at build time), and the visible-plus-front-porch span.

Two single-cycle strobes tell downstream timing blocks where they are in the line. `lineStart` rises together with the falling edge of the sync output. `visStart` marks the first clock after the back porch has run out. Vertical timing and pixel shifting are handled by other blocks, which count or wait on these strobes. The configuration is taken once. Any later configuration word is ignored until the next reset.

Top module: `hsync_gen`

## Requirements
- R1: From reset until the first line begins, `hsyncN` stays 1 and `visStart` stays 0.
- R2: When idle, a `cfgValid` cycle with both `cfgSyncPix` and `cfgTailPix` nonzero is captured. In the very next cycle `lineStart` is 1 and `hsyncN` is 0.
- R3: A `cfgValid` cycle while idle in which either length field is 0 is ignored: the block stays idle and produces no `lineStart`.
- R4: Within every line, `hsyncN` is 0 for exactly `cfgSyncPix` × `PIX_CLKS` consecutive cycles.
- R5: `visStart` is 1 exactly `BACK_PIX` × `PIX_CLKS` cycles after the first cycle in which `hsyncN` is back at 1 (480 cycles with the defaults).
- R6: Consecutive `lineStart` pulses are exactly (`cfgSyncPix` + `BACK_PIX` + `cfgTailPix`) × `PIX_CLKS` cycles apart. For example, 64/656 gives 3360 cycles.
- R7: `lineStart` is 1 exactly in the cycles where `hsyncN` has just fallen from 1 to 0. Both strobes are one cycle wide.
- R8: Once lines are running, `cfgValid` has no effect: the line timing keeps the captured lengths.
- R9: Exactly one `visStart` occurs between consecutive `lineStart` pulses, and `hsyncN` is 1 from that `visStart` until the next `lineStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgValid | input | 1 | Configuration word valid |
| cfgSyncPix | input | PIX_W | Sync pulse length in pixel periods |
| cfgTailPix | input | PIX_W | Visible plus front porch length in pixel periods |
| hsyncN | output | 1 | Horizontal sync, active low |
| lineStart | output | 1 | One-cycle strobe at the start of each sync pulse |
| visStart | output | 1 | One-cycle strobe at the end of the back porch |

## Verification
The bound checker tests the following on every cycle: that the block is quiet before the first line, that the sync pulse, back porch and line lengths match the lengths it captured, that `lineStart` lines up with every sync fall, that both strobes are one cycle wide, and that there is exactly one `visStart` per line. Only the bench scenarios can show that the default 64/656 timing gives an 840-pixel line and that the one-by-one pixel corner still works. They also show that a zero-length word leaves the block idle and that a second configuration word leaves later lines unchanged, because in each case the effect is observed several lines after the stimulus.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_BACK = 2'd2,
    PH_VIS  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_SYNC = 2'd1,
    LD_BACK = 2'd2,
    LD_VIS  = 2'd3
  } load_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  capture;
    logic  dec;
    load_e load;
  } ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic cfgOk;
    logic cntZero;
  } stat_t;

endpackage

// File: rtl/hsync_dp.sv
module hsync_dp
  import hsync_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int PIX_CLKS = 4,
  parameter int BACK_PIX = 120,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] cfgSyncPix,
  input  logic [PIX_W-1:0] cfgTailPix,
  input  ctl_t             ctl,
  output stat_t            stat
);

  localparam logic [CNT_W-1:0] BACK_LOAD = CNT_W'(BACK_PIX * PIX_CLKS - 1);
  localparam bit PIX_POW2 = ((PIX_CLKS & (PIX_CLKS - 1)) == 0);

  logic [PIX_W-1:0] syncReg;
  logic [PIX_W-1:0] tailReg;
  logic [PIX_W-1:0] selLen;
  logic [CNT_W-1:0] scaledLen;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cnt;

  // captured lengths, written only on the capture strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg <= '0;
      tailReg <= '0;
    end else if (ctl.capture) begin
      syncReg <= cfgSyncPix;
      tailReg <= cfgTailPix;
    end
  end

  // pick the length for the phase about to begin
  always_comb begin
    unique case (ctl.load)
      LD_SYNC: selLen = ctl.capture ? cfgSyncPix : syncReg;
      LD_VIS:  selLen = tailReg;
      default: selLen = '0;
    endcase
  end

  // pixel periods to clocks
  generate
    if (PIX_POW2) begin : g_shift
      assign scaledLen = CNT_W'(selLen) << $clog2(PIX_CLKS);
    end else begin : g_mul
      assign scaledLen = CNT_W'(selLen) * CNT_W'(PIX_CLKS);
    end
  endgenerate

  always_comb begin
    if (ctl.load == LD_BACK) loadVal = BACK_LOAD;
    else                     loadVal = scaledLen - CNT_W'(1);
  end

  // phase counter counts down to zero, last cycle of a phase at zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load != LD_NONE) begin
      cnt <= loadVal;
    end else if (ctl.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign stat.cntZero = (cnt == '0);
  assign stat.cfgOk   = (cfgSyncPix != '0) && (cfgTailPix != '0);

endmodule

// File: rtl/hsync_ctl.sv
module hsync_ctl
  import hsync_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  cfgValid,
  input  stat_t stat,
  output ctl_t  ctl,
  output logic  hsyncN,
  output logic  lineStart,
  output logic  visStart
);

  phase_e phase;
  phase_e phaseNext;

  always_comb begin
    phaseNext   = phase;
    ctl.capture = 1'b0;
    ctl.dec     = 1'b0;
    ctl.load    = LD_NONE;
    unique case (phase)
      PH_IDLE: begin
        if (cfgValid && stat.cfgOk) begin
          ctl.capture = 1'b1;
          ctl.load    = LD_SYNC;
          phaseNext   = PH_SYNC;
        end
      end
      PH_SYNC: begin
        if (stat.cntZero) begin
          ctl.load  = LD_BACK;
          phaseNext = PH_BACK;
        end else begin
          ctl.dec = 1'b1;
        end
      end
      PH_BACK: begin
        if (stat.cntZero) begin
          ctl.load  = LD_VIS;
          phaseNext = PH_VIS;
        end else begin
          ctl.dec = 1'b1;
        end
      end
      PH_VIS: begin
        if (stat.cntZero) begin
          ctl.load  = LD_SYNC;
          phaseNext = PH_SYNC;
        end else begin
          ctl.dec = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  // outputs registered from the next phase so they align with it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      hsyncN    <= 1'b1;
      lineStart <= 1'b0;
      visStart  <= 1'b0;
    end else begin
      phase     <= phaseNext;
      hsyncN    <= (phaseNext != PH_SYNC);
      lineStart <= (phaseNext == PH_SYNC) && (phase != PH_SYNC);
      visStart  <= (phaseNext == PH_VIS) && (phase != PH_VIS);
    end
  end

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen
  import hsync_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int PIX_CLKS = 4,
  parameter int BACK_PIX = 120
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgValid,
  input  logic [PIX_W-1:0] cfgSyncPix,
  input  logic [PIX_W-1:0] cfgTailPix,
  output logic             hsyncN,
  output logic             lineStart,
  output logic             visStart
);

  localparam int MAX_PIX = (BACK_PIX > (2 ** PIX_W)) ? BACK_PIX : (2 ** PIX_W);
  localparam int CNT_W   = $clog2(MAX_PIX * PIX_CLKS) + 1;

  ctl_t  ctl;
  stat_t stat;

  hsync_ctl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgValid  (cfgValid),
    .stat      (stat),
    .ctl       (ctl),
    .hsyncN    (hsyncN),
    .lineStart (lineStart),
    .visStart  (visStart)
  );

  hsync_dp #(
    .PIX_W    (PIX_W),
    .PIX_CLKS (PIX_CLKS),
    .BACK_PIX (BACK_PIX),
    .CNT_W    (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgSyncPix (cfgSyncPix),
    .cfgTailPix (cfgTailPix),
    .ctl        (ctl),
    .stat       (stat)
  );

endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk #(
  parameter int PIX_W    = 12,
  parameter int PIX_CLKS = 4,
  parameter int BACK_PIX = 120
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgValid,
  input logic [PIX_W-1:0] cfgSyncPix,
  input logic [PIX_W-1:0] cfgTailPix,
  input logic             hsyncN,
  input logic             lineStart,
  input logic             visStart
);

  logic begun;
  logic sawVis;
  logic idleCfgOk;
  int   syncCap;
  int   tailCap;
  int   lowCnt;
  int   highCnt;
  int   lineCnt;

  assign idleCfgOk = !begun && !lineStart && cfgValid &&
                     (cfgSyncPix != '0) && (cfgTailPix != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      begun   <= 1'b0;
      sawVis  <= 1'b0;
      syncCap <= 0;
      tailCap <= 0;
      lowCnt  <= 0;
      highCnt <= 0;
      lineCnt <= 0;
    end else begin
      if (lineStart) begun <= 1'b1;
      if (idleCfgOk) begin
        syncCap <= int'(cfgSyncPix);
        tailCap <= int'(cfgTailPix);
      end
      if (lineStart)     sawVis <= 1'b0;
      else if (visStart) sawVis <= 1'b1;
      lowCnt  <= hsyncN ? 0 : lowCnt + 1;
      highCnt <= hsyncN ? highCnt + 1 : 0;
      lineCnt <= lineStart ? 1 : lineCnt + 1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!begun && !lineStart) |-> (hsyncN && !visStart));

  p_cfg_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    idleCfgOk |=> (lineStart && !hsyncN));

  p_zero_cfg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!begun && !lineStart && cfgValid &&
     ((cfgSyncPix == '0) || (cfgTailPix == '0))) |=> !lineStart);

  p_sync_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsyncN) && begun) |-> (lowCnt == syncCap * PIX_CLKS));

  p_back_porch_r5: assert property (@(posedge clk) disable iff (!rstN)
    visStart |-> (hsyncN && highCnt == BACK_PIX * PIX_CLKS));

  p_line_period_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && begun) |-> (lineCnt == (syncCap + BACK_PIX + tailCap) * PIX_CLKS));

  p_start_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> (!hsyncN && $past(hsyncN)));

  p_fall_marked_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hsyncN) |-> lineStart);

  p_line_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart);

  p_vis_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    visStart |=> !visStart);

  p_one_vis_r9: assert property (@(posedge clk) disable iff (!rstN)
    visStart |-> !sawVis);

  p_vis_seen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && begun) |-> sawVis);

  p_high_after_vis_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sawVis && !lineStart) |-> hsyncN);

endmodule

bind hsync_gen hsync_gen_chk #(
  .PIX_W    (PIX_W),
  .PIX_CLKS (PIX_CLKS),
  .BACK_PIX (BACK_PIX)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cfgValid   (cfgValid),
  .cfgSyncPix (cfgSyncPix),
  .cfgTailPix (cfgTailPix),
  .hsyncN     (hsyncN),
  .lineStart  (lineStart),
  .visStart   (visStart)
);

// File: tb/hsync_gen_tb_top.sv
module hsync_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 12;
  localparam int PIX_CLKS   = 4;
  localparam int BACK_PIX   = 120;
  localparam int LOOP_LIMIT = 40000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgValid = 1'b0;
  logic [PIX_W-1:0] cfgSyncPix = '0;
  logic [PIX_W-1:0] cfgTailPix = '0;
  logic             hsyncN;
  logic             lineStart;
  logic             visStart;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hsync_gen #(
    .PIX_W    (PIX_W),
    .PIX_CLKS (PIX_CLKS),
    .BACK_PIX (BACK_PIX)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgValid   (cfgValid),
    .cfgSyncPix (cfgSyncPix),
    .cfgTailPix (cfgTailPix),
    .hsyncN     (hsyncN),
    .lineStart  (lineStart),
    .visStart   (visStart)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    cfgValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // watches idle outputs for n cycles, returns count of misbehaving cycles
  task automatic idle_watch(input int n, output int badCycles);
    badCycles = 0;
    for (int i = 0; i < n; i++) begin
      if (!hsyncN || lineStart || visStart) badCycles++;
      @(negedge clk);
    end
  endtask

  // applies one config word; checks first line begins next cycle (R2)
  task automatic apply_cfg(input int s, input int t);
    cfgSyncPix = PIX_W'(s);
    cfgTailPix = PIX_W'(t);
    cfgValid = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    check("R2 lineStart after capture", int'(lineStart), 1);
    check("R2 hsyncN low after capture", int'(hsyncN), 0);
  endtask

  task automatic wait_line();
    for (int i = 0; i < LOOP_LIMIT && !lineStart; i++) @(negedge clk);
  endtask

  // called in a lineStart cycle; measures the line up to the next lineStart
  task automatic measure_line(input int s, input int t);
    int lowC = 0;
    int backC = 0;
    int period = 0;
    int lsCount = 0;
    int visCount = 0;
    int highBad = 0;
    for (int i = 0; i < LOOP_LIMIT && !hsyncN; i++) begin
      if (lineStart) lsCount++;
      lowC++; period++;
      @(negedge clk);
    end
    for (int i = 0; i < LOOP_LIMIT && !visStart; i++) begin
      backC++; period++;
      @(negedge clk);
    end
    for (int i = 0; i < LOOP_LIMIT && !lineStart; i++) begin
      if (visStart) visCount++;
      if (!hsyncN) highBad++;
      period++;
      @(negedge clk);
    end
    check("R4 sync low cycles", lowC, s * PIX_CLKS);
    check("R5 back porch cycles", backC, BACK_PIX * PIX_CLKS);
    check("R6 line period", period, (s + BACK_PIX + t) * PIX_CLKS);
    check("R7 lineStart width", lsCount, 1);
    check("R7 visStart width", visCount, 1);
    check("R9 hsyncN high after visStart", highBad, 0);
  endtask

  task automatic test_idle_r1();
    int b;
    do_reset();
    check("R1 hsyncN after reset", int'(hsyncN), 1);
    idle_watch(200, b);
    check("R1 quiet idle cycles", b, 0);
  endtask

  task automatic test_zero_cfg_r3();
    int b;
    do_reset();
    cfgSyncPix = '0; cfgTailPix = PIX_W'(10); cfgValid = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    idle_watch(100, b);
    check("R3 zero sync ignored", b, 0);
    cfgSyncPix = PIX_W'(10); cfgTailPix = '0; cfgValid = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    idle_watch(100, b);
    check("R3 zero tail ignored", b, 0);
    apply_cfg(3, 7);
    measure_line(3, 7);
  endtask

  task automatic test_default_line();
    do_reset();
    apply_cfg(64, 656);
    measure_line(64, 656);
    measure_line(64, 656);
  endtask

  task automatic test_min_line();
    do_reset();
    apply_cfg(1, 1);
    measure_line(1, 1);
    measure_line(1, 1);
  endtask

  task automatic test_reconfig_r8();
    do_reset();
    apply_cfg(8, 30);
    @(negedge clk);
    cfgSyncPix = PIX_W'(2); cfgTailPix = PIX_W'(3); cfgValid = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    wait_line();
    check("R8 line continues after late cfg", int'(lineStart), 1);
    measure_line(8, 30);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_idle_r1();
    test_zero_cfg_r3();
    test_default_line();
    test_min_line();
    test_reconfig_r8();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule